// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a 64-bit effective address into a real address. It walks a three-level radix tree held in memory. A translation request carries five things: the effective address, the access kind, a privilege flag, a process identifier and the table-base register value. The walker first reads the partition table to find the process table. It then reads the process entry to find the root directory, and then reads one entry at each of the three tree levels. All reads are doublewords over a single-outstanding memory port. Every doubleword in memory is stored with its most significant byte at the lowest address, so the walker byte-reverses each response before it decodes it.

The walk ends in one of two ways. On success, the walker reports the real address and the non-cacheable attribute of the page. On failure, it reports a fault code: address out of range, translation missing, or access not permitted. The request side uses a valid/ready handshake and only one walk runs at a time. `req_ready` is high only while the walker is idle, so a requester holds `req_valid` and its fields until it sees ready. On the memory request side, the walker holds `mem_req_valid` and the address steady until `mem_req_ready` is sampled high. The response side has no back-pressure: `mem_rsp_valid` is a one-cycle pulse that the walker always accepts. The result is a one-cycle `done` pulse with no back-pressure.

Top module: `radix_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0 and `done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the cycle in which `done` is raised; it is 1 again in that cycle.
- R3: The walker issues its reads in this order:
  - first at `{tbr[55:12], 12'h000} + 8`;
  - then at the process-table base plus 16 times the PID;
  - then at each level's base plus 8 times that level's index. The indices are EA[38:30], EA[29:21] and EA[20:12], taken in that order.
  
  Every read address is a multiple of 8.
- R4: Every doubleword read is byte-reversed before it is used, so byte 0 of the memory word becomes bits 63:56 of the entry.
- R5: The memory port has at most one read outstanding. `mem_req_valid` and `mem_req_addr` hold steady while `mem_req_ready` is 0. No new request is made until the response for the previous one has arrived.
- R6: If EA[63:39] is not zero, `done` rises in the cycle after acceptance with fault code 1, and no memory read is issued.
- R7: Fault code 2 (missing translation) ends the walk as soon as one of these entries is read:
  - a zero partition entry or a zero process entry;
  - a directory entry with bit 63 clear, or with bit 62 set;
  - a leaf entry without both bit 63 and bit 62 set.
  
  The process-table base is taken from partition bits 55:12. Directory bases are taken from bits 55:8 of the process and directory entries.
- R8: Access kind 0 is load, 1 is store, 2 is fetch, and 3 is treated as a load. The leaf entry must grant the access: a store needs bit 1, a fetch needs bit 0 and a load needs bit 2. If bit 3 (privileged-only) is set and `req_priv` is 0, the access is refused. A refused access gives fault code 3.
- R9: On success, the fault code is 0, `ra` is `{8'h00, leaf[55:12], EA[11:0]}` and `nc` equals leaf bit 5. On any fault, `ra` is 0 and `nc` is 0.
- R10: `done` rises in the cycle after the final response is taken, and is 1 only in cycles where a result is being reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_ea | input | 64 | Effective address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 1 | Privileged access |
| req_pid | input | PID_W | Process identifier |
| req_tbr | input | 64 | Table-base register (partition table base) |
| mem_req_valid | output | 1 | Doubleword read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Read address |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 64 | Read data, as stored in memory |
| done | output | 1 | Result pulse |
| fault | output | 2 | 0 none, 1 range, 2 missing, 3 permission |
| ra | output | 64 | Real address |
| nc | output | 1 | Page is non-cacheable |

## Verification
The bench builds the walker with its default parameters: an 8-bit PID, three levels and 9 index bits per level. These values give a 39-bit space, so the range fault can be triggered at bit 39 and at bit 63, and the last index value 511 can be reached at every level in a single walk. PID 255 reaches the last process slot of a 4 kB process table. A leaf whose page number is all ones checks that bits 55:12 of the entry reach `ra` intact. A memory model with changing ready stalls and response latency exercises the hold and single-outstanding rules on every read.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int ENTRY_W    = 64;
  localparam int PAGE_BITS  = 12;
  localparam int RA_MSB     = 55;
  localparam int DIR_LSB    = 8;
  localparam int BIT_VALID  = 63;
  localparam int BIT_LEAF   = 62;
  localparam int BIT_EXEC   = 0;
  localparam int BIT_WRITE  = 1;
  localparam int BIT_READ   = 2;
  localparam int BIT_PRIV   = 3;
  localparam int BIT_NOCACHE = 5;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_OTHER = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_MISS  = 2'd2,
    FLT_PERM  = 2'd3
  } flt_e;
endpackage

// File: rtl/rw_byte_rev.sv
module rw_byte_rev #(
  parameter int NBYTES = 8
) (
  input  logic [8*NBYTES-1:0] din,
  output logic [8*NBYTES-1:0] dout
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
  end
endmodule

// File: rtl/rw_entry_eval.sv
module rw_entry_eval
  import rw_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int STEP_W = 3
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [STEP_W-1:0]  step,
  output logic               bad,
  output logic               is_last,
  output logic [ENTRY_W-1:0] next_base
);
  localparam int STEPS = LEVELS + 2;

  logic [ENTRY_W-1:0] page_base;
  logic [ENTRY_W-1:0] dir_base;
  logic               unused_fields;

  assign page_base = {{(ENTRY_W-1-RA_MSB){1'b0}}, entry[RA_MSB:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign dir_base  = {{(ENTRY_W-1-RA_MSB){1'b0}}, entry[RA_MSB:DIR_LSB], {DIR_LSB{1'b0}}};
  assign unused_fields = ^{entry[BIT_LEAF-1:RA_MSB+1], entry[DIR_LSB-1:0]};

  always_comb begin
    is_last = (step == STEP_W'(STEPS-1));
    if (step == STEP_W'(0)) begin
      // partition entry: process-table base
      bad       = (entry == '0);
      next_base = page_base;
    end else if (step == STEP_W'(1)) begin
      // process entry: root directory base
      bad       = (entry == '0);
      next_base = dir_base;
    end else if (is_last) begin
      bad       = !entry[BIT_VALID] || !entry[BIT_LEAF];
      next_base = page_base;
    end else begin
      bad       = !entry[BIT_VALID] || entry[BIT_LEAF];
      next_base = dir_base;
    end
  end
endmodule

// File: rtl/rw_perm_check.sv
module rw_perm_check
  import rw_pkg::*;
(
  input  acc_e       kind,
  input  logic       priv,
  input  logic [3:0] flags,
  output logic       allow
);
  logic granted;

  always_comb begin
    unique case (kind)
      ACC_STORE: granted = flags[BIT_WRITE];
      ACC_FETCH: granted = flags[BIT_EXEC];
      default:   granted = flags[BIT_READ];
    endcase
    allow = granted && (priv || !flags[BIT_PRIV]);
  end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rw_pkg::*;
#(
  parameter int PID_W  = 8,
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_ea,
  input  logic [1:0]       req_kind,
  input  logic             req_priv,
  input  logic [PID_W-1:0] req_pid,
  input  logic [63:0]      req_tbr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic [1:0]       fault,
  output logic [63:0]      ra,
  output logic             nc
);
  localparam int VA_BITS = PAGE_BITS + LEVELS * IDX_W;
  localparam int STEPS   = LEVELS + 2;
  localparam int STEP_W  = $clog2(STEPS);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e                st_q;
  logic [STEP_W-1:0]  step_q;
  logic [VA_BITS-1:0] ea_q;
  acc_e               kind_q;
  logic               priv_q;
  logic [PID_W-1:0]   pid_q;
  logic [63:0]        base_q;
  logic               done_q;
  flt_e               fault_q;
  logic [63:0]        ra_q;
  logic               nc_q;

  logic [IDX_W-1:0]   lvl_idx [LEVELS];
  logic [IDX_W-1:0]   sel_idx;
  logic [63:0]        entry;
  logic               ent_bad;
  logic               ent_last;
  logic [63:0]        ent_next;
  logic               perm_ok;
  logic               range_bad;
  logic               accept;
  logic               unused_tbr;

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign accept        = req_valid && req_ready;
  assign range_bad     = |req_ea[63:VA_BITS];
  assign unused_tbr    = ^{req_tbr[63:RA_MSB+1], req_tbr[PAGE_BITS-1:0]};

  // index fields, top level first
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign lvl_idx[g] = ea_q[PAGE_BITS + IDX_W*(LEVELS-g) - 1 -: IDX_W];
  end

  always_comb begin
    sel_idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (step_q == STEP_W'(k + 2)) sel_idx = lvl_idx[k];
    end
  end

  always_comb begin
    if (step_q == STEP_W'(0))      mem_req_addr = base_q + 64'd8;
    else if (step_q == STEP_W'(1)) mem_req_addr = base_q + (64'(pid_q) << 4);
    else                           mem_req_addr = base_q + (64'(sel_idx) << 3);
  end

  rw_byte_rev #(.NBYTES(8)) u_rev (
    .din  (mem_rsp_data),
    .dout (entry)
  );

  rw_entry_eval #(.LEVELS(LEVELS), .STEP_W(STEP_W)) u_eval (
    .entry     (entry),
    .step      (step_q),
    .bad       (ent_bad),
    .is_last   (ent_last),
    .next_base (ent_next)
  );

  rw_perm_check u_perm (
    .kind  (kind_q),
    .priv  (priv_q),
    .flags (entry[3:0]),
    .allow (perm_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      ea_q    <= '0;
      kind_q  <= ACC_LOAD;
      priv_q  <= 1'b0;
      pid_q   <= '0;
      base_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      ra_q    <= '0;
      nc_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            ea_q   <= req_ea[VA_BITS-1:0];
            kind_q <= acc_e'(req_kind);
            priv_q <= req_priv;
            pid_q  <= req_pid;
            step_q <= '0;
            base_q <= {{(63-RA_MSB){1'b0}}, req_tbr[RA_MSB:PAGE_BITS], {PAGE_BITS{1'b0}}};
            if (range_bad) begin
              done_q  <= 1'b1;
              fault_q <= FLT_RANGE;
              ra_q    <= '0;
              nc_q    <= 1'b0;
            end else begin
              st_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_bad || ent_last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              if (ent_bad) begin
                fault_q <= FLT_MISS;
                ra_q    <= '0;
                nc_q    <= 1'b0;
              end else if (!perm_ok) begin
                fault_q <= FLT_PERM;
                ra_q    <= '0;
                nc_q    <= 1'b0;
              end else begin
                fault_q <= FLT_NONE;
                ra_q    <= {ent_next[63:PAGE_BITS], ea_q[PAGE_BITS-1:0]};
                nc_q    <= entry[BIT_NOCACHE];
              end
            end else begin
              base_q <= ent_next;
              step_q <= step_q + STEP_W'(1);
              st_q   <= ST_REQ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done  = done_q;
  assign fault = fault_q;
  assign ra    = ra_q;
  assign nc    = nc_q;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int PID_W   = 8,
  parameter int VA_BITS = 39
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_ea,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [63:0]      mem_req_addr,
  input logic             mem_rsp_valid,
  input logic             done,
  input logic [1:0]       fault,
  input logic [63:0]      ra,
  input logic             nc
);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_one_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (|req_ea[63:VA_BITS])) |=> (done && fault == 2'd1));

  p_clean_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> (ra == 64'd0 && !nc));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind radix_walker radix_walker_chk #(.PID_W(PID_W), .VA_BITS(VA_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_ea        (req_ea),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .fault         (fault),
  .ra            (ra),
  .nc            (nc)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb;
  localparam int PID_W = 8;
  localparam logic [63:0] M4K = 64'h00ff_ffff_ffff_f000;
  localparam logic [63:0] M256 = 64'h00ff_ffff_ffff_ff00;
  localparam logic [63:0] PGD = 64'h12000;
  localparam logic [63:0] PRM = 64'h187; // ref, chg, rd, wr, ex

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic [63:0]      req_ea;
  logic [1:0]       req_kind;
  logic             req_priv;
  logic [PID_W-1:0] req_pid;
  logic [63:0]      req_tbr;
  logic             mem_req_valid;
  logic             mem_req_ready;
  logic [63:0]      mem_req_addr;
  logic             mem_rsp_valid;
  logic [63:0]      mem_rsp_data;
  logic             done;
  logic [1:0]       fault;
  logic [63:0]      ra;
  logic             nc;

  radix_walker #(.PID_W(PID_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_priv(req_priv), .req_pid(req_pid), .req_tbr(req_tbr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .ra(ra), .nc(nc)
  );

  logic [63:0] mem [logic [63:0]];
  int n_checks = 0;
  int n_fail = 0;

  function automatic logic [63:0] swap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] rd_ent(input logic [63:0] a);
    return mem.exists(a) ? swap64(mem[a]) : 64'd0;
  endfunction

  task automatic put_be(input logic [63:0] a, input logic [63:0] v);
    mem[a] = swap64(v);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tree building
  logic [63:0] free_ptr = 64'h13000;

  task automatic pte_slot(input logic [63:0] ea, output logic [63:0] slot);
    logic [63:0] d, m;
    d = rd_ent(PGD + 64'(ea[38:30]) * 8);
    if (d == 0) begin
      d = 64'h8000_0000_0000_0009 | free_ptr;
      put_be(PGD + 64'(ea[38:30]) * 8, d);
      free_ptr += 64'h1000;
    end
    m = d & M256;
    d = rd_ent(m + 64'(ea[29:21]) * 8);
    if (d == 0) begin
      d = 64'h8000_0000_0000_0009 | free_ptr;
      put_be(m + 64'(ea[29:21]) * 8, d);
      free_ptr += 64'h1000;
    end
    slot = (d & M256) + 64'(ea[20:12]) * 8;
  endtask

  task automatic map_page(input logic [63:0] ea, input logic [63:0] pa, input logic [63:0] perm);
    logic [63:0] s;
    pte_slot(ea, s);
    put_be(s, 64'hC000_0000_0000_0000 | (pa & M4K) | perm);
  endtask

  // behavioural reference walk
  logic [63:0] exp_q [$];
  logic [1:0]  exp_fault;
  logic [63:0] exp_ra;
  logic        exp_nc;

  task automatic model_walk(input logic [63:0] ea, input logic [1:0] kind, input logic priv,
                            input logic [PID_W-1:0] pid, input logic [63:0] tbr);
    logic [63:0] a, e, base;
    logic need;
    exp_q.delete();
    exp_fault = 0; exp_ra = 0; exp_nc = 0;
    if (ea[63:39] != 0) begin exp_fault = 1; return; end
    a = (tbr & M4K) + 8; exp_q.push_back(a); e = rd_ent(a);
    if (e == 0) begin exp_fault = 2; return; end
    base = e & M4K;
    a = base + 64'(pid) * 16; exp_q.push_back(a); e = rd_ent(a);
    if (e == 0) begin exp_fault = 2; return; end
    base = e & M256;
    for (int lv = 0; lv < 3; lv++) begin
      a = base + ((ea >> (30 - 9*lv)) & 64'h1ff) * 8;
      exp_q.push_back(a); e = rd_ent(a);
      if (!e[63]) begin exp_fault = 2; return; end
      if (lv < 2) begin
        if (e[62]) begin exp_fault = 2; return; end
        base = e & M256;
      end else begin
        if (!e[62]) begin exp_fault = 2; return; end
        need = (kind == 2'd1) ? e[1] : (kind == 2'd2) ? e[0] : e[2];
        if (!need || (e[3] && !priv)) begin exp_fault = 3; return; end
        exp_ra = (e & M4K) | (ea & 64'hfff);
        exp_nc = e[5];
      end
    end
  endtask

  // memory responder and per-cycle comparison
  bit          busy = 0, done_due = 0, pend = 0, hold_prev = 0;
  int          wcnt = 0, lat = 0, cyc = 0;
  int          n_acc = 0, n_done = 0;
  logic [63:0] paddr, prev_addr;
  logic [1:0]  last_fault;
  logic [63:0] last_ra;
  logic        last_nc;
  string       cur_tag = "none";

  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        if (wcnt == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = mem.exists(paddr) ? mem[paddr] : 64'd0;
          pend = 0;
        end else wcnt--;
      end
      cyc++;
      mem_req_ready = (cyc % 4) != 2;
      #3;
      if (rst_n) begin
        chk("R2 ready", 64'(req_ready), 64'(!busy || done_due));
        chk("R10 done timing", 64'(done), 64'(done_due));
        if (done) begin
          chk({cur_tag, " fault"}, 64'(fault), 64'(exp_fault));
          chk({cur_tag, " ra"}, ra, exp_ra);
          chk({cur_tag, " nc"}, 64'(nc), 64'(exp_nc));
          chk("R3 read count", 64'(exp_q.size()), 64'd0);
          last_fault = fault; last_ra = ra; last_nc = nc;
          busy = 0; n_done++;
        end
        done_due = 0;
        if (hold_prev) begin
          chk("R5 hold valid", 64'(mem_req_valid), 64'd1);
          chk("R5 hold addr", mem_req_addr, prev_addr);
        end
        hold_prev = 0;
        if (mem_req_valid) begin
          if (exp_q.size() == 0 || pend || mem_rsp_valid) begin
            chk("R5 unexpected read", 64'd1, 64'd0);
          end else if (mem_req_ready) begin
            chk("R3 read addr", mem_req_addr, exp_q[0]);
            void'(exp_q.pop_front());
            pend = 1; paddr = mem_req_addr; wcnt = lat; lat = (lat + 1) % 3;
          end else begin
            hold_prev = 1; prev_addr = mem_req_addr;
          end
        end
        if (mem_rsp_valid && exp_q.size() == 0) done_due = 1;
        if (req_valid && req_ready) begin
          model_walk(req_ea, req_kind, req_priv, req_pid, req_tbr);
          busy = 1; n_acc++;
          if (exp_q.size() == 0) done_due = 1;
        end
      end
    end
  end

  task automatic run(input string tag, input logic [63:0] ea, input logic [1:0] kind,
                     input logic priv, input logic [PID_W-1:0] pid, input logic [63:0] tbr);
    int tgt;
    @(negedge clk);
    cur_tag = tag;
    req_ea = ea; req_kind = kind; req_priv = priv; req_pid = pid; req_tbr = tbr;
    req_valid = 1;
    tgt = n_acc + 1;
    wait (n_acc == tgt);
    @(negedge clk);
    req_valid = 0;
    wait (n_done == tgt);
  endtask

  task automatic expect_res(input string tag, input logic [1:0] f, input logic [63:0] a, input logic n);
    chk({tag, " fixed fault"}, 64'(last_fault), 64'(f));
    chk({tag, " fixed ra"}, last_ra, a);
    chk({tag, " fixed nc"}, 64'(last_nc), 64'(n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  localparam logic [63:0] TBR = 64'h10000;
  logic [63:0] s;

  initial begin
    rst_n = 0; req_valid = 0; req_ea = 0; req_kind = 0; req_priv = 0; req_pid = 0; req_tbr = 0;
    // memory image
    put_be(64'h10008, 64'h11000);
    put_be(64'h11010, 64'hA000_0000_0000_0009 | PGD);
    map_page(64'h40_3000, 64'h00AB_CDEF_0000, PRM);
    map_page(64'h40_4000, 64'h5000, 64'h184);
    map_page(64'h40_5000, 64'h00FF_FFFF_FFFF_F000, 64'h1AC);
    map_page(64'h7F_FFFF_F000, 64'h123_4000, PRM);
    pte_slot(64'h40_7000, s);
    put_be(s, 64'h8000_0000_0000_9007);
    put_be(PGD + 5*8, 64'hC000_0000_0000_1007);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #3;
    chk("R1 ready", 64'(req_ready), 64'd1);
    chk("R1 mem valid", 64'(mem_req_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);

    run("R9 R4 load", 64'h40_3123, 2'd0, 0, 1, TBR);
    expect_res("R9 load", 0, 64'h00AB_CDEF_0123, 0);
    run("R8 store ok", 64'h40_3008, 2'd1, 0, 1, TBR);
    expect_res("R8 store ok", 0, 64'h00AB_CDEF_0008, 0);
    run("R8 fetch ok", 64'h40_3ffc, 2'd2, 0, 1, TBR);
    run("R8 load ro", 64'h40_4010, 2'd0, 0, 1, TBR);
    expect_res("R8 load ro", 0, 64'h5010, 0);
    run("R8 store ro", 64'h40_4010, 2'd1, 1, 1, TBR);
    expect_res("R8 store ro", 3, 0, 0);
    run("R8 fetch noexec", 64'h40_4000, 2'd2, 1, 1, TBR);
    expect_res("R8 fetch noexec", 3, 0, 0);
    run("R8 priv page user", 64'h40_5abc, 2'd0, 0, 1, TBR);
    expect_res("R8 priv page user", 3, 0, 0);
    run("R9 priv nc", 64'h40_5abc, 2'd0, 1, 1, TBR);
    expect_res("R9 priv nc", 0, 64'h00FF_FFFF_FFFF_FABC, 1);
    run("R3 top index", 64'h7F_FFFF_FFFF, 2'd0, 0, 1, TBR);
    expect_res("R3 top index", 0, 64'h123_4FFF, 0);
    run("R7 leaf zero", 64'h40_6000, 2'd0, 1, 1, TBR);
    expect_res("R7 leaf zero", 2, 0, 0);
    run("R7 dir missing", 64'h8000_0000, 2'd0, 1, 1, TBR);
    expect_res("R7 dir missing", 2, 0, 0);
    run("R7 dir is leaf", 64'h1_4000_0000, 2'd0, 1, 1, TBR);
    expect_res("R7 dir is leaf", 2, 0, 0);
    run("R7 leaf no bit62", 64'h40_7000, 2'd0, 1, 1, TBR);
    expect_res("R7 leaf no bit62", 2, 0, 0);
    run("R7 pid empty", 64'h40_3000, 2'd0, 1, 8'd255, TBR);
    expect_res("R7 pid empty", 2, 0, 0);
    run("R7 part empty", 64'h40_3000, 2'd0, 1, 1, 64'h20000);
    expect_res("R7 part empty", 2, 0, 0);
    run("R6 range bit39", 64'h80_0000_0000, 2'd0, 1, 1, TBR);
    expect_res("R6 range bit39", 1, 0, 0);
    run("R6 range bit63", 64'h8000_0000_0040_3000, 2'd0, 1, 1, TBR);
    expect_res("R6 range bit63", 1, 0, 0);
    run("R9 after range", 64'h40_3004, 2'd3, 0, 1, TBR);
    expect_res("R9 after range", 0, 64'h00AB_CDEF_0004, 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule